// File: doc/BRIEF.md
# BCD Watchdog Timer with Interrupt Pin Router

This block is a repeating countdown watchdog. Two byte-wide BCD registers set its period. The low byte counts hundredths of a second and the high byte counts whole seconds, so the period runs from 0.01 s to 99.99 s. A 100 Hz tick decrements an internal four-digit BCD counter. When the counter runs out, the watchdog flag sets and the counter reloads from the stored period, so the alarm keeps repeating for as long as software does not service it. Software services the watchdog by reading or writing either period register. Either access reloads the counter and clears the flag.

A command register decides how the watchdog flag and a time-of-day alarm flag reach two interrupt pins. The time-of-day flag is set and cleared by a neighbouring block. The command register can swap which interrupt goes to which pin, mask each interrupt, choose the polarity of pin B, and choose level or pulse output. In pulse mode the pulse width is timed by a millisecond-class tick, and the watchdog flag clears itself when its pulse ends. The pin outputs are logic levels with polarity already applied. Bus accesses are single-cycle strobes, and read data is valid in the same cycle as the strobe.

Top module: `wdog_irq_router`

## Requirements
- R1: The period is stored as two BCD bytes: register select 0 holds hundredths and register select 1 holds seconds. Both read back exactly the value last written, and both read 0 after reset.
- R2: Any read or write strobe to select 0 or select 1 reloads the down-counter from the period and clears the watchdog flag. After such an access, the flag needs a full period of 100 Hz ticks to set again.
- R3: With a nonzero period of P hundredths, the watchdog flag sets on the P-th 100 Hz tick after a reload. The counter then reloads by itself and expires again after another P ticks.
- R4: A period of 0 (both bytes zero) disables the watchdog, and the flag never sets.
- R5: The command register at select 2 has this layout: bit 7 transfer enable (driven on `xfer_en`), bit 6 swap, bit 5 pin-B active-high, bit 4 pulse mode, bit 3 watchdog mask, bit 2 time-of-day mask, bit 1 watchdog flag, bit 0 time-of-day flag. Bits 1 and 0 are read-only, and writes leave them unchanged. The register resets to 0x00.
- R6: With swap=0 the watchdog interrupt drives pin A and the time-of-day interrupt drives pin B. With swap=1 the two are exchanged, and the change takes effect at once, even while an interrupt is active.
- R7: Pin A is active-low. Pin B is active-high when bit 5 is 1 and active-low when it is 0. An idle pin sits at its inactive level.
- R8: In pulse mode a new flag drives its pin active for PULSE_TICKS (default 4) millisecond ticks, which is never less than 3 ms. At the end of the pulse the watchdog flag clears. In level mode the pin stays active for as long as the flag is set.
- R9: A mask bit of 1 holds its interrupt inactive on the pin, but the matching flag still sets and reads back as 1.
- R10: `tod_set` sets the time-of-day flag and `tod_clr` clears it. If both are high in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_100hz | input | 1 | One-cycle pulse at 100 Hz that decrements the counter |
| tick_ms | input | 1 | One-cycle pulse about every 1 ms that times the pulse width |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 = hundredths, 1 = seconds, 2 = command, 3 = reads zero |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| tod_set | input | 1 | Sets the time-of-day flag |
| tod_clr | input | 1 | Clears the time-of-day flag |
| xfer_en | output | 1 | Transfer-enable bit for the neighbouring clock block |
| pin_a_lvl | output | 1 | Pin A level (active-low) |
| pin_b_lvl | output | 1 | Pin B level (polarity selectable) |

## Verification
The hardest situations to reach from the ports are the self-repeat in pulse mode and the exact expiry tick. A pulse has to end, and its flag has to clear on its own, before a second expiry with no bus access in between can be observed. The bench therefore uses pulse mode with a two-tick period. It steps the millisecond tick one pulse at a time to see the release on the fourth tick, then issues two more 100 Hz ticks to see the flag return. It checks expiry one tick early and on the exact tick for several BCD periods, up to 99.99 s, which makes the borrow chain cross every digit.

// File: rtl/wdog_irq_pkg.sv
package wdog_irq_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 2;
  localparam logic [SEL_W-1:0] SEL_HUND = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SEC  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CMD  = 2'd2;

  typedef struct packed {
    logic te;
    logic swap;
    logic b_high;
    logic pulse;
    logic wd_mask;
    logic tod_mask;
  } cmd_t;
endpackage

// File: rtl/wdog_bcd_counter.sv
module wdog_bcd_counter #(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] period,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_dec;
  logic         run;

  always_comb begin
    logic borrow;
    borrow  = 1'b1;
    cnt_dec = cnt_q;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (cnt_q[4*i +: 4] == 4'd0) begin
          cnt_dec[4*i +: 4] = 4'd9;
        end else begin
          cnt_dec[4*i +: 4] = cnt_q[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
  end

  assign run    = tick && !reload && (period != '0);
  assign expire = run && (cnt_q <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (reload) cnt_q <= reload_val;
    else if (expire) cnt_q <= period;
    else if (run)    cnt_q <= cnt_dec;
  end
endmodule

// File: rtl/irq_pulse_shaper.sv
module irq_pulse_shaper #(
  parameter int PULSE_TICKS = 4,
  localparam int CW = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic tick_ms,
  output logic active,
  output logic done
);
  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign done   = act_q && !start && !abort && tick_ms && (cnt_q == CW'(PULSE_TICKS - 1));
  assign active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (abort || done) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q && tick_ms) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/wdog_irq_router.sv
module wdog_irq_router
  import wdog_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_100hz,
  input  logic             tick_ms,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tod_set,
  input  logic             tod_clr,
  output logic             xfer_en,
  output logic             pin_a_lvl,
  output logic             pin_b_lvl
);
  localparam int PW = 2 * REG_W;

  logic [REG_W-1:0] hund_q, sec_q;
  cmd_t             cmd_q;
  logic             waf_q, tdf_q;
  logic             acc_period;
  logic [PW-1:0]    period, period_nxt;
  logic             expire;
  logic             wd_pact, wd_pdone, tod_pact, tod_pdone;
  logic             wd_act, tod_act, a_act, b_act;
  logic             wr_hund, wr_sec, wr_cmd;

  assign wr_hund    = reg_en && reg_we && (reg_sel == SEL_HUND);
  assign wr_sec     = reg_en && reg_we && (reg_sel == SEL_SEC);
  assign wr_cmd     = reg_en && reg_we && (reg_sel == SEL_CMD);
  assign acc_period = reg_en && ((reg_sel == SEL_HUND) || (reg_sel == SEL_SEC));
  assign period     = {sec_q, hund_q};
  assign period_nxt = {wr_sec ? reg_wdata : sec_q, wr_hund ? reg_wdata : hund_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hund_q <= '0;
      sec_q  <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr_hund) hund_q <= reg_wdata;
      if (wr_sec)  sec_q  <= reg_wdata;
      if (wr_cmd)  cmd_q  <= reg_wdata[7:2];
    end
  end

  wdog_bcd_counter #(.DIGITS(PW / 4)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (acc_period),
    .reload_val (period_nxt),
    .period     (period),
    .tick       (tick_100hz),
    .expire     (expire)
  );

  irq_pulse_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_wd_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (expire),
    .abort   (acc_period),
    .tick_ms (tick_ms),
    .active  (wd_pact),
    .done    (wd_pdone)
  );

  irq_pulse_shaper #(.PULSE_TICKS(PULSE_TICKS)) u_tod_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tod_set && !tdf_q),
    .abort   (tod_clr && !tod_set),
    .tick_ms (tick_ms),
    .active  (tod_pact),
    .done    (tod_pdone)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waf_q <= 1'b0;
      tdf_q <= 1'b0;
    end else begin
      if (expire)                            waf_q <= 1'b1;
      else if (acc_period)                   waf_q <= 1'b0;
      else if (wd_pdone && cmd_q.pulse)      waf_q <= 1'b0;
      if (tod_set)      tdf_q <= 1'b1;
      else if (tod_clr) tdf_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_HUND: reg_rdata = hund_q;
      SEL_SEC:  reg_rdata = sec_q;
      SEL_CMD:  reg_rdata = {cmd_q, waf_q, tdf_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign wd_act    = !cmd_q.wd_mask  && (cmd_q.pulse ? wd_pact  : waf_q);
  assign tod_act   = !cmd_q.tod_mask && (cmd_q.pulse ? tod_pact : tdf_q);
  assign a_act     = cmd_q.swap ? tod_act : wd_act;
  assign b_act     = cmd_q.swap ? wd_act  : tod_act;
  assign pin_a_lvl = !a_act;
  assign pin_b_lvl = cmd_q.b_high ? b_act : !b_act;
  assign xfer_en   = cmd_q.te;
  // tod_pdone only ends the pin pulse; the time-of-day flag is owned by tod_clr
endmodule

// File: rtl/wdog_irq_router_chk.sv
module wdog_irq_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_100hz,
  input logic        acc_period,
  input logic        waf_q,
  input logic [15:0] period,
  input logic [5:0]  cmd_bits,
  input logic        pin_a_lvl
);
  // R2
  period_access_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_period |=> !waf_q);
  // R3
  flag_rises_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waf_q) |-> $past(tick_100hz));
  // R4
  zero_period_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 16'h0 && !waf_q) |=> !waf_q);
  // R6
  wd_on_pin_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits[4:2] == 3'b000 && waf_q && !cmd_bits[1]) |-> !pin_a_lvl);
  // R9
  wd_mask_holds_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_bits[4] && cmd_bits[1]) |-> pin_a_lvl);
endmodule

bind wdog_irq_router wdog_irq_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_100hz (tick_100hz),
  .acc_period (acc_period),
  .waf_q      (waf_q),
  .period     (period),
  .cmd_bits   (cmd_q),
  .pin_a_lvl  (pin_a_lvl)
);

// File: tb/wdog_irq_router_bench.sv
`timescale 1ns/1ps
module wdog_irq_router_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_100hz = 0, tick_ms = 0, reg_en = 0, reg_we = 0, tod_set = 0, tod_clr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic xfer_en, pin_a_lvl, pin_b_lvl;
  int n_run = 0, n_fail = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  wdog_irq_router u_wdog_irq_router (.*);

  localparam int NV = 6;
  localparam logic [15:0] PER_TAB [NV] = '{16'h0001, 16'h0010, 16'h0100, 16'h0099, 16'h0205, 16'h9999};
  localparam int          EXP_TAB [NV] = '{1, 10, 100, 99, 205, 9999};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(logic we, logic [1:0] sel, logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    reg_en = 1; reg_we = we; reg_sel = sel; reg_wdata = d;
    #1 r = reg_rdata;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    logic [7:0] dummy;
    acc(1'b1, sel, d, dummy);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_100hz = 1;
      @(negedge clk); tick_100hz = 0;
    end
  endtask

  task automatic msticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_ms = 1;
      @(negedge clk); tick_ms = 0;
    end
  endtask

  task automatic cmd_rd(output logic [7:0] r);
    acc(1'b0, 2'd2, 8'h00, r);
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: run hung");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    cmd_rd(rd);                      check("R5 reset cmd", rd, 8'h00);
    acc(0, 2'd0, 0, rd);             check("R1 reset hund", rd, 8'h00);
    check("R7 idle pin A", pin_a_lvl, 1);
    check("R7 idle pin B", pin_b_lvl, 1);

    // table walk: exact expiry tick, R1 readback, R3, R6 level on pin A
    for (int v = 0; v < NV; v++) begin
      wr(2'd1, PER_TAB[v][15:8]);
      wr(2'd0, PER_TAB[v][7:0]);
      acc(0, 2'd1, 0, rd);           check("R1 sec readback", rd, PER_TAB[v][15:8]);
      acc(0, 2'd0, 0, rd);           check("R1 hund readback", rd, PER_TAB[v][7:0]);
      ticks(EXP_TAB[v] - 1);
      cmd_rd(rd);                    check("R3 not yet expired", rd[1], 0);
      ticks(1);
      cmd_rd(rd);                    check("R3 expired on tick", rd[1], 1);
      check("R6 wd on pin A low", pin_a_lvl, 0);
      acc(0, 2'd0, 0, rd);
      cmd_rd(rd);                    check("R2 read clears flag", rd[1], 0);
    end

    // R2 mid-count reload
    wr(2'd1, 8'h00); wr(2'd0, 8'h05);
    ticks(4);
    acc(0, 2'd1, 0, rd);
    ticks(4);
    cmd_rd(rd);                      check("R2 reload delays expiry", rd[1], 0);
    ticks(1);
    cmd_rd(rd);                      check("R2 full period after reload", rd[1], 1);
    // R5 writes to flag bits ignored
    wr(2'd2, 8'h00);
    cmd_rd(rd);                      check("R5 write keeps waf", rd[1], 1);
    wr(2'd0, 8'h05);
    cmd_rd(rd);                      check("R2 write clears flag", rd[1], 0);
    check("R2 pin A released", pin_a_lvl, 1);
    wr(2'd2, 8'h83);
    cmd_rd(rd);                      check("R5 flag bits read-only", rd, 8'h80);
    check("R5 xfer_en", xfer_en, 1);
    wr(2'd2, 8'h00);

    // R4 zero period disables
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    ticks(300);
    cmd_rd(rd);                      check("R4 disabled no flag", rd[1], 0);

    // R10 / R6 / R7 / R9 routing
    @(negedge clk); tod_set = 1; @(negedge clk); tod_set = 0;
    cmd_rd(rd);                      check("R10 tdf set", rd[0], 1);
    check("R6 tod on pin B active-low", pin_b_lvl, 0);
    wr(2'd2, 8'h60);                 // swap, pin B active-high
    check("R6 swapped tod on pin A", pin_a_lvl, 0);
    check("R7 pin B idle active-high", pin_b_lvl, 0);
    wr(2'd1, 8'h00); wr(2'd0, 8'h03);
    ticks(3);
    check("R7 wd on pin B high", pin_b_lvl, 1);
    wr(2'd2, 8'h64);                 // tod mask
    check("R9 tod masked on pin A", pin_a_lvl, 1);
    cmd_rd(rd);                      check("R9 tdf still set", rd[0], 1);
    wr(2'd2, 8'h68);                 // wd mask
    check("R9 wd masked on pin B", pin_b_lvl, 0);
    cmd_rd(rd);                      check("R9 waf still set", rd[1], 1);
    @(negedge clk); tod_set = 1; tod_clr = 1; @(negedge clk); tod_set = 0; tod_clr = 0;
    cmd_rd(rd);                      check("R10 set wins", rd[0], 1);
    @(negedge clk); tod_clr = 1; @(negedge clk); tod_clr = 0;
    cmd_rd(rd);                      check("R10 tdf cleared", rd[0], 0);

    // R8 pulse mode and R3 repeat
    wr(2'd2, 8'h10);
    wr(2'd1, 8'h00); wr(2'd0, 8'h02);
    ticks(2);
    check("R8 pulse starts", pin_a_lvl, 0);
    msticks(3);
    check("R8 still active after 3 ms", pin_a_lvl, 0);
    cmd_rd(rd);                      check("R8 waf held in pulse", rd[1], 1);
    msticks(1);
    check("R8 pulse ends", pin_a_lvl, 1);
    cmd_rd(rd);                      check("R8 waf self-clears", rd[1], 0);
    ticks(2);
    cmd_rd(rd);                      check("R3 repeats without access", rd[1], 1);
    msticks(4);
    cmd_rd(rd);                      check("R8 second pulse clears", rd[1], 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule